// File: doc/BRIEF.md
# Cycle, Time and Retired-Instruction Counter Bank

This block keeps two free-running 64-bit event counters, one counting clock cycles and one counting retired instructions, and presents them, with an externally supplied 64-bit time value, through a simple register port. The port has an address, a write enable, write data and combinational read data. Each counter can be reached at two kinds of address. One set is a read-only view meant for unprivileged code. The other is a read/write view for the most privileged level. A small inhibit register can freeze either counter.

The counters are always 64 bits wide, whatever the data width of the port (XLEN, 32 or 64). An ordinary access sees only the low XLEN bits. With a 32-bit port, a second set of addresses reaches bits 63:32. Writing there replaces only the upper word, and writing the ordinary address replaces only the lower word. A core pipeline feeds the retire pulse and reads or writes the counters when it executes register-access instructions. Privilege checks belong to the surrounding logic.

Top module: `csr_counter_bank`

## Requirements
- R1: After reset, both counters and the inhibit register read zero.
- R2: The cycle counter adds one on every clock edge, and the retired counter adds one on every edge where `retire_i` is high. Neither counts while its inhibit bit is set.
- R3: Addresses 0xC00, 0xC01 and 0xC02 read the low XLEN bits of the cycle counter, `time_i` and the retired counter. Addresses 0xB00 and 0xB02 read the same bits of the cycle and retired counters.
- R4: With XLEN=32, addresses 0xC80, 0xC81, 0xC82, 0xB80 and 0xB82 read bits 63:32 of cycle, time, retired, cycle and retired. With XLEN=64 these addresses are not decoded: `csr_hit_o` is low and the read data is zero.
- R5: A write to 0xB00 or 0xB02 replaces the low XLEN bits of that counter, and bits 63:XLEN keep their value.
- R6: With XLEN=32, a write to 0xB80 or 0xB82 replaces bits 63:32 of that counter, and bits 31:0 keep their value.
- R7: A write to a counter takes priority over that edge's increment. The next read returns exactly the written value.
- R8: An increment carries from bit 31 into bit 32. All ones wraps to zero.
- R9: The inhibit register is at 0x320. Bit 0 freezes the cycle counter and bit 2 freezes the retired counter. Bit 1 and every other bit read zero. A written value controls counting from the following edge onward.
- R10: Writes to the read-only addresses (0xC00 to 0xC82) and to addresses that are not decoded change nothing. Reads have no side effect, and `csr_hit_o` is high exactly for the decoded addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One pulse per retired instruction |
| time_i | input | 64 | External time value |
| csr_addr_i | input | 12 | Register address |
| csr_we_i | input | 1 | Write enable for the current address |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data |
| csr_hit_o | output | 1 | Address is decoded by this block |

## Verification
The bench builds two copies side by side: one with XLEN=32 and one with XLEN=64, both driven by the same address and write stream. The 32-bit copy makes the high-word aliases reachable. With it the bench checks that a low-word write and a high-word write each leave the other half untouched, and that the carry crosses bit 31. The 64-bit copy shows the same high-word addresses falling through undecoded, and it is where a full-width write and a 64-bit wrap are checked.

// File: rtl/csr_counter_pkg.sv
package csr_counter_pkg;

   localparam int CNT_W  = 64;
   localparam int HALF_W = 32;
   localparam int ADDR_W = 12;

   // Address map (values fixed by the instruction encoding that reaches this block)
   localparam logic [ADDR_W-1:0] A_U_CYC    = 12'hC00;
   localparam logic [ADDR_W-1:0] A_U_TIM    = 12'hC01;
   localparam logic [ADDR_W-1:0] A_U_RET    = 12'hC02;
   localparam logic [ADDR_W-1:0] A_U_CYC_HI = 12'hC80;
   localparam logic [ADDR_W-1:0] A_U_TIM_HI = 12'hC81;
   localparam logic [ADDR_W-1:0] A_U_RET_HI = 12'hC82;
   localparam logic [ADDR_W-1:0] A_M_CYC    = 12'hB00;
   localparam logic [ADDR_W-1:0] A_M_RET    = 12'hB02;
   localparam logic [ADDR_W-1:0] A_M_CYC_HI = 12'hB80;
   localparam logic [ADDR_W-1:0] A_M_RET_HI = 12'hB82;
   localparam logic [ADDR_W-1:0] A_M_INH    = 12'h320;

   // Inhibit bit positions
   localparam int INH_CYC_BIT = 0;
   localparam int INH_RET_BIT = 2;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_CYC_LO,
      SRC_CYC_HI,
      SRC_TIM_LO,
      SRC_TIM_HI,
      SRC_RET_LO,
      SRC_RET_HI,
      SRC_INH
   } rd_src_e;

   typedef struct packed {
      logic cyc_lo;
      logic cyc_hi;
      logic ret_lo;
      logic ret_hi;
      logic inh;
   } wr_strobe_t;

endpackage

// File: rtl/csr_counter_decode.sv
module csr_counter_decode
   import csr_counter_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   output rd_src_e           src_o,
   output logic              hit_o,
   output wr_strobe_t        wr_o
);

   localparam bit HAS_HI = (XLEN < CNT_W);

   rd_src_e hi_src;
   logic    hi_hit;
   logic    hi_wr_cyc;
   logic    hi_wr_ret;

   generate
      if (HAS_HI) begin : g_hi_dec
         always_comb begin
            hi_src    = SRC_NONE;
            hi_hit    = 1'b0;
            hi_wr_cyc = 1'b0;
            hi_wr_ret = 1'b0;
            case (addr_i)
               A_U_CYC_HI: begin hi_src = SRC_CYC_HI; hi_hit = 1'b1; end
               A_U_TIM_HI: begin hi_src = SRC_TIM_HI; hi_hit = 1'b1; end
               A_U_RET_HI: begin hi_src = SRC_RET_HI; hi_hit = 1'b1; end
               A_M_CYC_HI: begin
                  hi_src    = SRC_CYC_HI;
                  hi_hit    = 1'b1;
                  hi_wr_cyc = we_i;
               end
               A_M_RET_HI: begin
                  hi_src    = SRC_RET_HI;
                  hi_hit    = 1'b1;
                  hi_wr_ret = we_i;
               end
               default: ;
            endcase
         end
      end else begin : g_no_hi
         assign hi_src    = SRC_NONE;
         assign hi_hit    = 1'b0;
         assign hi_wr_cyc = 1'b0;
         assign hi_wr_ret = 1'b0;
      end
   endgenerate

   always_comb begin
      src_o = SRC_NONE;
      hit_o = 1'b0;
      wr_o  = '0;
      case (addr_i)
         A_U_CYC: begin src_o = SRC_CYC_LO; hit_o = 1'b1; end
         A_U_TIM: begin src_o = SRC_TIM_LO; hit_o = 1'b1; end
         A_U_RET: begin src_o = SRC_RET_LO; hit_o = 1'b1; end
         A_M_CYC: begin
            src_o     = SRC_CYC_LO;
            hit_o     = 1'b1;
            wr_o.cyc_lo = we_i;
         end
         A_M_RET: begin
            src_o     = SRC_RET_LO;
            hit_o     = 1'b1;
            wr_o.ret_lo = we_i;
         end
         A_M_INH: begin
            src_o     = SRC_INH;
            hit_o     = 1'b1;
            wr_o.inh  = we_i;
         end
         default: begin
            src_o       = hi_src;
            hit_o       = hi_hit;
            wr_o.cyc_hi = hi_wr_cyc;
            wr_o.ret_hi = hi_wr_ret;
         end
      endcase
   end

endmodule

// File: rtl/csr_counter64.sv
module csr_counter64
   import csr_counter_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [XLEN-1:0]  wdata_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam bit SPLIT = (XLEN < CNT_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   // Software write wins over the increment of the same edge
   always_comb begin
      cnt_d = cnt_q;
      if (wr_lo_i) begin
         cnt_d[XLEN-1:0] = wdata_i;
      end else if (wr_hi_i) begin
         cnt_d[CNT_W-1:HALF_W] = wdata_i[HALF_W-1:0];
      end else if (inc_i) begin
         cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R7: written low word is what gets stored
   a_r7_write_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_lo_i |=> cnt_o[XLEN-1:0] == $past(wdata_i));

   // R2: counting step of exactly one (R8: carries across all 64 bits)
   a_r2_step_one : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !wr_lo_i && !wr_hi_i) |=> cnt_o == $past(cnt_o) + 64'd1);

   // R2/R9: no increment and no write means no change
   a_r2_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));

   generate
      if (SPLIT) begin : g_split_chk
         // R5: low-word write keeps the upper bits
         a_r5_keep_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_lo_i |=> cnt_o[CNT_W-1:XLEN] == $past(cnt_o[CNT_W-1:XLEN]));
         // R6: high-word write keeps the lower bits and stores the data above
         a_r6_high_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_hi_i && !wr_lo_i) |=> (cnt_o[HALF_W-1:0] == $past(cnt_o[HALF_W-1:0]))
                                   && (cnt_o[CNT_W-1:HALF_W] == $past(wdata_i[HALF_W-1:0])));
      end
   endgenerate

endmodule

// File: rtl/csr_counter_inhibit.sv
module csr_counter_inhibit
   import csr_counter_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic            inh_cyc_o,
   output logic            inh_ret_o,
   output logic [XLEN-1:0] rd_o
);

   localparam logic [XLEN-1:0] WR_MASK =
      (XLEN'(1) << INH_CYC_BIT) | (XLEN'(1) << INH_RET_BIT);

   logic [XLEN-1:0] inh_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)   inh_q <= '0;
      else if (wr_i) inh_q <= wdata_i & WR_MASK;
   end

   assign inh_cyc_o = inh_q[INH_CYC_BIT];
   assign inh_ret_o = inh_q[INH_RET_BIT];
   assign rd_o      = inh_q;

   // R9: written enable bits appear on the next edge
   a_r9_inh_update : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (inh_cyc_o == $past(wdata_i[INH_CYC_BIT]))
            && (inh_ret_o == $past(wdata_i[INH_RET_BIT])));

endmodule

// File: rtl/csr_counter_bank.sv
module csr_counter_bank
   import csr_counter_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              retire_i,
   input  logic [CNT_W-1:0]  time_i,
   input  logic [ADDR_W-1:0] csr_addr_i,
   input  logic              csr_we_i,
   input  logic [XLEN-1:0]   csr_wdata_i,
   output logic [XLEN-1:0]   csr_rdata_o,
   output logic              csr_hit_o
);

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("csr_counter_bank: XLEN must be 32 or 64");
      end
   endgenerate

   rd_src_e          src;
   wr_strobe_t       wr;
   logic             inh_cyc;
   logic             inh_ret;
   logic [XLEN-1:0]  inh_rd;
   logic [CNT_W-1:0] cyc_cnt;
   logic [CNT_W-1:0] ret_cnt;

   csr_counter_decode #(.XLEN(XLEN)) u_decode (
      .addr_i (csr_addr_i),
      .we_i   (csr_we_i),
      .src_o  (src),
      .hit_o  (csr_hit_o),
      .wr_o   (wr)
   );

   csr_counter_inhibit #(.XLEN(XLEN)) u_inhibit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr.inh),
      .wdata_i   (csr_wdata_i),
      .inh_cyc_o (inh_cyc),
      .inh_ret_o (inh_ret),
      .rd_o      (inh_rd)
   );

   csr_counter64 #(.XLEN(XLEN)) u_cycle (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (!inh_cyc),
      .wr_lo_i (wr.cyc_lo),
      .wr_hi_i (wr.cyc_hi),
      .wdata_i (csr_wdata_i),
      .cnt_o   (cyc_cnt)
   );

   csr_counter64 #(.XLEN(XLEN)) u_retired (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (retire_i && !inh_ret),
      .wr_lo_i (wr.ret_lo),
      .wr_hi_i (wr.ret_hi),
      .wdata_i (csr_wdata_i),
      .cnt_o   (ret_cnt)
   );

   always_comb begin
      csr_rdata_o = '0;
      case (src)
         SRC_CYC_LO: csr_rdata_o = cyc_cnt[XLEN-1:0];
         SRC_CYC_HI: csr_rdata_o[HALF_W-1:0] = cyc_cnt[CNT_W-1:HALF_W];
         SRC_TIM_LO: csr_rdata_o = time_i[XLEN-1:0];
         SRC_TIM_HI: csr_rdata_o[HALF_W-1:0] = time_i[CNT_W-1:HALF_W];
         SRC_RET_LO: csr_rdata_o = ret_cnt[XLEN-1:0];
         SRC_RET_HI: csr_rdata_o[HALF_W-1:0] = ret_cnt[CNT_W-1:HALF_W];
         SRC_INH:    csr_rdata_o = inh_rd;
         default:    csr_rdata_o = '0;
      endcase
   end

   // R3: time low word passes straight through
   a_r3_time_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == A_U_TIM) |-> csr_rdata_o == time_i[XLEN-1:0]);

   // R9: bit 1 of the inhibit register never reads as one
   a_r9_bit1_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_addr_i == A_M_INH) |-> !csr_rdata_o[1]);

   // R10: undecoded reads return zero
   a_r10_miss_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !csr_hit_o |-> csr_rdata_o == '0);

   generate
      if (XLEN == CNT_W) begin : g_wide_chk
         // R4: no high-word aliases at full width
         a_r4_no_alias : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (csr_addr_i == A_M_CYC_HI || csr_addr_i == A_M_RET_HI ||
             csr_addr_i == A_U_CYC_HI || csr_addr_i == A_U_TIM_HI ||
             csr_addr_i == A_U_RET_HI) |-> !csr_hit_o);
      end
   endgenerate

endmodule

// File: tb/csr_counter_bank_bench.sv
module csr_counter_bank_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire = 1'b0;
   logic [63:0] time_v = '0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wd = '0;
   logic [63:0] wd64 = '0;
   logic [31:0] rd32;
   logic [63:0] rd64;
   logic        hit32;
   logic        hit64;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csr_counter_bank #(.XLEN(32)) u_csr_counter_bank (
      .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .time_i(time_v),
      .csr_addr_i(addr), .csr_we_i(we), .csr_wdata_i(wd),
      .csr_rdata_o(rd32), .csr_hit_o(hit32));

   csr_counter_bank #(.XLEN(64)) u_csr_counter_bank_x64 (
      .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .time_i(time_v),
      .csr_addr_i(addr), .csr_we_i(we), .csr_wdata_i(wd64),
      .csr_rdata_o(rd64), .csr_hit_o(hit64));

   // Expected state, kept from the requirements
   logic [63:0] m_cyc32, m_ret32, m_cyc64, m_ret64;
   logic [2:0]  m_inh32, m_inh64;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cyc32 <= '0; m_ret32 <= '0; m_inh32 <= '0;
         m_cyc64 <= '0; m_ret64 <= '0; m_inh64 <= '0;
      end else begin
         // 32-bit port
         if (we && addr == 12'hB00)      m_cyc32[31:0]  <= wd;
         else if (we && addr == 12'hB80) m_cyc32[63:32] <= wd;
         else if (!m_inh32[0])           m_cyc32 <= m_cyc32 + 64'd1;
         if (we && addr == 12'hB02)      m_ret32[31:0]  <= wd;
         else if (we && addr == 12'hB82) m_ret32[63:32] <= wd;
         else if (retire && !m_inh32[2]) m_ret32 <= m_ret32 + 64'd1;
         if (we && addr == 12'h320)      m_inh32 <= wd[2:0] & 3'b101;
         // 64-bit port
         if (we && addr == 12'hB00)      m_cyc64 <= wd64;
         else if (!m_inh64[0])           m_cyc64 <= m_cyc64 + 64'd1;
         if (we && addr == 12'hB02)      m_ret64 <= wd64;
         else if (retire && !m_inh64[2]) m_ret64 <= m_ret64 + 64'd1;
         if (we && addr == 12'h320)      m_inh64 <= wd64[2:0] & 3'b101;
      end
   end

   function automatic logic [31:0] exp32(input logic [11:0] a);
      case (a)
         12'hC00, 12'hB00: return m_cyc32[31:0];
         12'hC80, 12'hB80: return m_cyc32[63:32];
         12'hC01:          return time_v[31:0];
         12'hC81:          return time_v[63:32];
         12'hC02, 12'hB02: return m_ret32[31:0];
         12'hC82, 12'hB82: return m_ret32[63:32];
         12'h320:          return {29'd0, m_inh32};
         default:          return 32'd0;
      endcase
   endfunction

   function automatic logic [63:0] exp64(input logic [11:0] a);
      case (a)
         12'hC00, 12'hB00: return m_cyc64;
         12'hC01:          return time_v;
         12'hC02, 12'hB02: return m_ret64;
         12'h320:          return {61'd0, m_inh64};
         default:          return 64'd0;
      endcase
   endfunction

   function automatic bit dec32(input logic [11:0] a);
      case (a)
         12'hC00, 12'hC01, 12'hC02, 12'hC80, 12'hC81, 12'hC82,
         12'hB00, 12'hB02, 12'hB80, 12'hB82, 12'h320: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit dec64(input logic [11:0] a);
      case (a)
         12'hC00, 12'hC01, 12'hC02, 12'hB00, 12'hB02, 12'h320: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(input logic [11:0] a);
      case (a)
         12'hC80, 12'hC81, 12'hC82, 12'hB80, 12'hB82: return "R4";
         12'hC00, 12'hC01, 12'hC02, 12'hB00, 12'hB02: return "R3";
         12'h320: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [11:0] pick_addr(input int unsigned k);
      case (k % 13)
         0: return 12'hC00;  1: return 12'hC01;  2: return 12'hC02;
         3: return 12'hC80;  4: return 12'hC81;  5: return 12'hC82;
         6: return 12'hB00;  7: return 12'hB02;  8: return 12'hB80;
         9: return 12'hB82; 10: return 12'h320; 11: return 12'hB01;
         default: return 12'(k >> 4);
      endcase
   endfunction

   // Compare both copies at the current address; called away from the clock edge
   task automatic check_now(input string req);
      n_chk++;
      if (rd32 !== exp32(addr) || hit32 !== dec32(addr)) begin
         n_fail++;
         $display("FAIL %s x32 addr=%h actual=%h/%b expected=%h/%b",
                  req, addr, rd32, hit32, exp32(addr), dec32(addr));
      end
      n_chk++;
      if (rd64 !== exp64(addr) || hit64 !== dec64(addr)) begin
         n_fail++;
         $display("FAIL %s x64 addr=%h actual=%h/%b expected=%h/%b",
                  req, addr, rd64, hit64, exp64(addr), dec64(addr));
      end
   endtask

   task automatic rd(input logic [11:0] a, input string req);
      @(negedge clk);
      addr = a; we = 1'b0; #1;
      check_now(req);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d,
                     input logic [63:0] d64);
      @(negedge clk);
      addr = a; we = 1'b1; wd = d; wd64 = d64;
   endtask

   task automatic expect32(input logic [11:0] a, input logic [31:0] v, input string req);
      @(negedge clk);
      addr = a; we = 1'b0; #1;
      n_chk++;
      if (rd32 !== v) begin
         n_fail++;
         $display("FAIL %s x32 addr=%h actual=%h expected=%h", req, a, rd32, v);
      end
   endtask

   initial begin
      void'($urandom(32'h1234_5678));
      time_v = 64'h0123_4567_89AB_CDEF;
      repeat (3) @(negedge clk);
      // R1: reset state
      addr = 12'hC00; #1; check_now("R1");
      addr = 12'hC02; #1; check_now("R1");
      addr = 12'h320; #1; check_now("R1");
      rst_n = 1'b1;
      // R2: counting after reset
      expect32(12'hC00, 32'd1, "R2");
      expect32(12'hB00, 32'd2, "R2");
      retire = 1'b1;
      rd(12'hC02, "R2");
      rd(12'hB02, "R2");
      retire = 1'b0;
      // R5/R7/R8: carry across bit 31
      wr(12'hB80, 32'h0000_0005, 64'd0);
      wr(12'hB00, 32'hFFFF_FFFF, 64'h0000_0003_FFFF_FFFF);
      expect32(12'hB00, 32'hFFFF_FFFF, "R7");
      expect32(12'hB80, 32'h0000_0006, "R8");
      rd(12'hC80, "R8");
      // R6: high write keeps low word
      wr(12'hB82, 32'hDEAD_BEEF, 64'd0);
      rd(12'hC82, "R6");
      rd(12'hC02, "R6");
      // R8: all-ones wraps
      wr(12'hB80, 32'hFFFF_FFFF, 64'd0);
      wr(12'hB00, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(12'hB00, "R8");
      expect32(12'hB80, 32'h0, "R8");
      // R9: inhibit
      wr(12'h320, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      expect32(12'h320, 32'h5, "R9");
      rd(12'hC00, "R9");
      retire = 1'b1;
      rd(12'hC00, "R9");
      rd(12'hC02, "R9");
      retire = 1'b0;
      wr(12'h320, 32'h0, 64'd0);
      rd(12'hC00, "R9");
      // R10: writes to read-only and undecoded addresses
      wr(12'hC00, 32'h1234, 64'h1234);
      rd(12'hC00, "R10");
      wr(12'hC82, 32'h55, 64'h55);
      rd(12'hC82, "R10");
      wr(12'h7FF, 32'h99, 64'h99);
      rd(12'h7FF, "R10");
      rd(12'hB80, "R4");
      // Random mix
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         addr   = pick_addr($urandom);
         we     = ($urandom % 3) == 0;
         wd     = $urandom;
         wd64   = {$urandom, $urandom};
         retire = $urandom % 2;
         if (($urandom % 8) == 0) time_v = {$urandom, $urandom};
         if (addr == 12'h320 && ($urandom % 2) == 0) begin
            wd = '0; wd64 = '0;
         end
         #1;
         check_now(req_of(addr));
      end
      @(negedge clk);
      we = 1'b0;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule